// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Selectable Trigger Mode

This block collects up to eight interrupt request lines, applies a per-level mask and drives a single interrupt line toward a processor. Among the requests that are pending, unmasked and not blocked, it picks the one with the best fixed priority. When the processor acknowledges, the block returns a vector equal to a base value plus the level number. It also records that level as in service. The in-service record holds off that level and every level of lower priority until software ends the interrupt through the command port.

Request detection can be edge-sensitive or level-sensitive. In edge mode, a rising edge on a request line is latched, and the latch clears on acknowledge. So one assertion of the line gives exactly one interrupt. In level mode, a request is pending for as long as its line is high. An end-of-interrupt issued while the device still holds its line high therefore raises the interrupt again at once. A board strap can pin the block in level mode. Two end-of-interrupt forms exist: a non-specific one that retires the best-priority level in service, and a specific one that names the level to retire.

Top module: `irqc_top`

## Requirements
- R1: Level 0 has the highest priority. When several eligible requests are pending, the acknowledge vector names the lowest-numbered one.
- R2: While a level is in service, requests on that level and on all higher-numbered levels do not raise `int_o`. A request on a lower-numbered level does raise it.
- R3: In edge mode, a single rising edge on a request line produces one interrupt only. If the line stays high after the end-of-interrupt, `int_o` stays low.
- R4: In level mode (configuration byte `0x0X` with bit 0 set), a request line that is still high when its in-service bit is cleared raises `int_o` again in the next cycle.
- R5: The command byte `0x60 | n` (n in 0..7) clears the in-service bit of level n only.
- R6: The command byte `0x20` clears the in-service bit of the lowest-numbered level currently in service.
- R7: Mask bit n (value `1<<n`) set keeps level n from raising `int_o` and leaves the in-service bits unchanged. Clearing the bit re-enables the level.
- R8: While `force_level_i` is high, `level_mode_o` reads 1 and the block runs in level mode. A configuration write with bit 0 clear has no effect on the mode.
- R9: An acknowledge while `int_o` is high presents `VEC_BASE + level` on `vector_o` in the same cycle. The level is then moved into service, and in edge mode its request latch is cleared.
- R10: After reset, no level is in service, no request is latched, all mask bits are set, status select chooses the request register, and edge mode is selected unless the strap is high.
- R11: A command byte with upper nibble 0 is a configuration write. Bit 0 selects level mode and bit 1 selects the in-service register (1) or the request register (0) for `cmd_rdata_o`. `mask_rdata_o` returns the mask. Any other command byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_level_i | input | 1 | Strap that pins level-sensitive detection |
| irq_req_i | input | 8 | Request lines, bit n is level n |
| cmd_wr_i | input | 1 | Command port write strobe |
| cmd_wdata_i | input | 8 | Command byte |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | New mask value |
| ack_i | input | 1 | Interrupt acknowledge, one cycle |
| int_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector, valid while `ack_i` and `int_o` are high |
| cmd_rdata_o | output | 8 | Request or in-service register, chosen by status select |
| mask_rdata_o | output | 8 | Current mask |
| level_mode_o | output | 1 | 1 when level-sensitive detection is in effect |

## Verification
The assertions assume that an acknowledge and a specific end-of-interrupt do not both occur in one cycle. The in-service bookkeeping they check would otherwise mix a set and a clear. They also assume that the strap is held steady while reset is released. The directed stimulus writes commands and acknowledges in separate cycles. It changes the strap only while reset is asserted. In edge mode it raises request lines only from low, so each scenario knows which edges the block has seen.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int unsigned CMD_W = 8;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_CFG,
    CMD_NS_EOI,
    CMD_SP_EOI
  } cmd_kind_e;

  function automatic cmd_kind_e decode_cmd(input logic [CMD_W-1:0] b);
    if (b[7:4] == 4'h0)        return CMD_CFG;
    if (b == 8'h20)            return CMD_NS_EOI;
    if (b[7:3] == 5'b01100)    return CMD_SP_EOI;
    return CMD_NONE;
  endfunction
endpackage

// File: rtl/irqc_prio_enc.sv
`timescale 1ns/1ps
module irqc_prio_enc #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/irqc_req_stage.sv
`timescale 1ns/1ps
module irqc_req_stage #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_mode_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      irr_q <= '0;
    end else begin
      req_q <= req_i;
      if (level_mode_i) irr_q <= '0;
      else              irr_q <= (irr_q & ~clr_i) | (req_i & ~req_q);
    end
  end

  assign pend_o = level_mode_i ? req_i : irr_q;
endmodule

// File: rtl/irqc_isr.sv
`timescale 1ns/1ps
module irqc_isr #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] isr_o,
  output logic         busy_o,
  output logic [W-1:0] top_o
);
  logic [N-1:0] isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~clr_i) | set_i;
  end

  irqc_prio_enc #(.N(N)) u_top (
    .req_i (isr_q),
    .any_o (busy_o),
    .idx_o (top_o)
  );

  assign isr_o = isr_q;
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_LVL    = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 64,
  localparam int unsigned LVL_W   = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             force_level_i,
  input  logic [N_LVL-1:0] irq_req_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             mask_wr_i,
  input  logic [N_LVL-1:0] mask_wdata_i,
  input  logic             ack_i,
  output logic             int_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [N_LVL-1:0] cmd_rdata_o,
  output logic [N_LVL-1:0] mask_rdata_o,
  output logic             level_mode_o
);
  logic             mode_q;
  logic             stat_isr_q;
  logic [N_LVL-1:0] mask_q;
  logic             level_mode;
  cmd_kind_e        kind;

  logic [N_LVL-1:0] pend;
  logic [N_LVL-1:0] isr_vec;
  logic             isr_busy;
  logic [LVL_W-1:0] isr_top;
  logic [N_LVL-1:0] unblk;
  logic [N_LVL-1:0] cand;
  logic [LVL_W-1:0] win;
  logic [N_LVL-1:0] grant;
  logic [N_LVL-1:0] eoi_clr;

  assign level_mode = mode_q | force_level_i;
  assign kind       = decode_cmd(cmd_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      stat_isr_q <= 1'b0;
      mask_q     <= '1;
    end else begin
      if (mask_wr_i) mask_q <= mask_wdata_i;
      if (cmd_wr_i && kind == CMD_CFG) begin
        mode_q     <= cmd_wdata_i[0];
        stat_isr_q <= cmd_wdata_i[1];
      end
    end
  end

  irqc_req_stage #(.N(N_LVL)) u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .level_mode_i (level_mode),
    .req_i        (irq_req_i),
    .clr_i        (grant),
    .pend_o       (pend)
  );

  irqc_isr #(.N(N_LVL)) u_isr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (grant),
    .clr_i  (eoi_clr),
    .isr_o  (isr_vec),
    .busy_o (isr_busy),
    .top_o  (isr_top)
  );

  // a level is eligible only if it outranks every level in service
  for (genvar g = 0; g < N_LVL; g++) begin : g_unblk
    assign unblk[g] = !isr_busy || (g < int'(isr_top));
  end

  assign cand = pend & ~mask_q & unblk;

  irqc_prio_enc #(.N(N_LVL)) u_win (
    .req_i (cand),
    .any_o (int_o),
    .idx_o (win)
  );

  always_comb begin
    grant = '0;
    if (ack_i && int_o) grant[win] = 1'b1;
  end

  always_comb begin
    eoi_clr = '0;
    if (cmd_wr_i) begin
      if (kind == CMD_NS_EOI && isr_busy) eoi_clr[isr_top] = 1'b1;
      if (kind == CMD_SP_EOI) eoi_clr[cmd_wdata_i[LVL_W-1:0]] = 1'b1;
    end
  end

  assign vector_o     = VEC_W'(VEC_BASE) + VEC_W'(win);
  assign cmd_rdata_o  = stat_isr_q ? isr_vec : pend;
  assign mask_rdata_o = mask_q;
  assign level_mode_o = level_mode;
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk #(
  parameter int unsigned N_LVL    = 8,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             force_level_i,
  input logic             level_mode_o,
  input logic             int_o,
  input logic             ack_i,
  input logic             cmd_wr_i,
  input logic [7:0]       cmd_wdata_i,
  input logic [N_LVL-1:0] mask_rdata_o,
  input logic [VEC_W-1:0] vector_o,
  input logic [N_LVL-1:0] isr,
  input logic [N_LVL-1:0] pend
);
  logic [VEC_W-1:0] vec_lvl;
  int unsigned      low_isr;

  assign vec_lvl = vector_o - VEC_W'(VEC_BASE);

  always_comb begin
    low_isr = N_LVL;
    for (int i = N_LVL - 1; i >= 0; i--) if (isr[i]) low_isr = i;
  end

  assert_force_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_level_i |-> level_mode_o);

  assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((pend & ~mask_rdata_o) != '0));

  assert_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && isr != '0) |-> (int'(vec_lvl) < int'(low_isr)));

  assert_spec_eoi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_wdata_i[7:3] == 5'b01100 && !ack_i) |=>
      (isr == ($past(isr) & ~(N_LVL'(1) << $past(cmd_wdata_i[LVL_W-1:0])))));

  assert_ack_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && !cmd_wr_i) |=> ($countones(isr) == $countones($past(isr)) + 1));

  assert_level_reint_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_mode_o && isr == '0 && (pend & ~mask_rdata_o) != '0) |-> int_o);
endmodule

bind irqc_top irqc_chk #(
  .N_LVL    (N_LVL),
  .LVL_W    (LVL_W),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .force_level_i (force_level_i),
  .level_mode_o  (level_mode_o),
  .int_o         (int_o),
  .ack_i         (ack_i),
  .cmd_wr_i      (cmd_wr_i),
  .cmd_wdata_i   (cmd_wdata_i),
  .mask_rdata_o  (mask_rdata_o),
  .vector_o      (vector_o),
  .isr           (isr_vec),
  .pend          (pend)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       force_level;
  logic [7:0] req;
  logic       cmd_wr;
  logic [7:0] cmd_wdata;
  logic       mask_wr;
  logic [7:0] mask_wdata;
  logic       ack;
  logic       int_o;
  logic [7:0] vector;
  logic [7:0] cmd_rdata;
  logic [7:0] mask_rdata;
  logic       level_mode;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] vec;

  always #10 clk = ~clk;

  irqc_top dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .force_level_i (force_level),
    .irq_req_i     (req),
    .cmd_wr_i      (cmd_wr),
    .cmd_wdata_i   (cmd_wdata),
    .mask_wr_i     (mask_wr),
    .mask_wdata_i  (mask_wdata),
    .ack_i         (ack),
    .int_o         (int_o),
    .vector_o      (vector),
    .cmd_rdata_o   (cmd_rdata),
    .mask_rdata_o  (mask_rdata),
    .level_mode_o  (level_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_ni = 1'b0; force_level = strap; req = '0; cmd_wr = 0; cmd_wdata = '0;
    mask_wr = 0; mask_wdata = '0; ack = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic wr_cmd(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = b;
    @(negedge clk); cmd_wr = 1'b0; cmd_wdata = '0; #1;
  endtask

  task automatic wr_mask(input logic [7:0] m);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = m;
    @(negedge clk); mask_wr = 1'b0; #1;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1; #1 v = vector;
    @(negedge clk); ack = 1'b0; #1;
  endtask

  task automatic set_req(input logic [7:0] r);
    @(negedge clk); req = r; #1;
  endtask

  task automatic t_reset_R10();
    do_reset(1'b0);
    chk("R10 int_o", int_o, 0);
    chk("R10 mask", mask_rdata, 8'hFF);
    chk("R10 mode", level_mode, 0);
    chk("R10 irr", cmd_rdata, 8'h00);
    wr_cmd(8'h02);
    chk("R10 isr", cmd_rdata, 8'h00);
  endtask

  task automatic t_edge_once_R3();
    do_reset(1'b0);
    wr_mask(8'h00);
    set_req(8'h08);
    step();
    chk("R3 int raised", int_o, 1);
    do_ack(vec);
    chk("R9 vector", vec, 8'h43);
    chk("R9 latch cleared", cmd_rdata, 8'h00);
    chk("R3 int low in service", int_o, 0);
    wr_cmd(8'h20);
    step();
    chk("R3 no second int", int_o, 0);
    set_req(8'h00);
  endtask

  task automatic t_priority_R1();
    do_reset(1'b0);
    wr_mask(8'h00);
    set_req(8'h24);
    step();
    do_ack(vec);
    chk("R1 best level", vec, 8'h42);
    chk("R2 lower blocked", int_o, 0);
    wr_cmd(8'h20);
    chk("R1 next int", int_o, 1);
    do_ack(vec);
    chk("R1 next vector", vec, 8'h45);
    wr_cmd(8'h20);
    set_req(8'h00);
  endtask

  task automatic t_nest_R2_R6();
    do_reset(1'b0);
    wr_mask(8'h00);
    wr_cmd(8'h02);
    set_req(8'h10);
    step();
    do_ack(vec);
    chk("R9 vec4", vec, 8'h44);
    set_req(8'h50);
    step();
    chk("R2 level6 held", int_o, 0);
    set_req(8'h52);
    step();
    chk("R2 level1 preempts", int_o, 1);
    do_ack(vec);
    chk("R2 vec1", vec, 8'h41);
    chk("R2 isr nested", cmd_rdata, 8'h12);
    wr_cmd(8'h20);
    chk("R6 clears best", cmd_rdata, 8'h10);
    chk("R6 level6 still held", int_o, 0);
    wr_cmd(8'h20);
    chk("R6 isr empty", cmd_rdata, 8'h00);
    chk("R2 level6 released", int_o, 1);
    do_ack(vec);
    chk("R2 vec6", vec, 8'h46);
    wr_cmd(8'h20);
    set_req(8'h00);
  endtask

  task automatic t_spec_eoi_R5();
    do_reset(1'b0);
    wr_mask(8'h00);
    wr_cmd(8'h02);
    set_req(8'h20);
    step();
    do_ack(vec);
    set_req(8'h22);
    step();
    do_ack(vec);
    chk("R5 isr setup", cmd_rdata, 8'h22);
    wr_cmd(8'h65);
    chk("R5 clears only 5", cmd_rdata, 8'h02);
    wr_cmd(8'h61);
    chk("R5 clears 1", cmd_rdata, 8'h00);
    set_req(8'h00);
  endtask

  task automatic t_level_R4();
    do_reset(1'b0);
    wr_mask(8'h00);
    wr_cmd(8'h01);
    chk("R4 level mode", level_mode, 1);
    set_req(8'h40);
    chk("R4 int on level", int_o, 1);
    do_ack(vec);
    chk("R4 vec6", vec, 8'h46);
    chk("R4 held in service", int_o, 0);
    wr_cmd(8'h66);
    chk("R4 re-interrupt", int_o, 1);
    set_req(8'h00);
    chk("R4 line low quiet", int_o, 0);
  endtask

  task automatic t_mask_R7();
    do_reset(1'b0);
    wr_cmd(8'h03);
    wr_mask(8'h08);
    set_req(8'h08);
    chk("R7 masked quiet", int_o, 0);
    wr_mask(8'h00);
    chk("R7 unmasked int", int_o, 1);
    do_ack(vec);
    wr_mask(8'h08);
    chk("R7 isr kept", cmd_rdata, 8'h08);
    chk("R11 mask read", mask_rdata, 8'h08);
    wr_cmd(8'h63);
    chk("R7 masked after eoi", int_o, 0);
    wr_mask(8'h00);
    chk("R7 re-enabled", int_o, 1);
    set_req(8'h00);
  endtask

  task automatic t_force_R8();
    do_reset(1'b1);
    chk("R8 strap mode", level_mode, 1);
    wr_cmd(8'h00);
    chk("R8 edge write ignored", level_mode, 1);
    wr_mask(8'h00);
    set_req(8'h01);
    chk("R8 level behaviour", int_o, 1);
    do_ack(vec);
    wr_cmd(8'h20);
    chk("R8 re-interrupt", int_o, 1);
    set_req(8'h00);
    do_reset(1'b0);
  endtask

  task automatic t_status_R11();
    do_reset(1'b0);
    set_req(8'h81);
    step();
    chk("R11 irr latched while masked", cmd_rdata, 8'h81);
    chk("R11 masked no int", int_o, 0);
    wr_cmd(8'h90);
    chk("R11 bad cmd no effect", cmd_rdata, 8'h81);
    chk("R11 bad cmd mode", level_mode, 0);
    wr_cmd(8'h02);
    chk("R11 isr select", cmd_rdata, 8'h00);
    set_req(8'h00);
  endtask

  initial begin
    #4_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; force_level = 1'b0; req = '0; cmd_wr = 0; cmd_wdata = '0;
    mask_wr = 0; mask_wdata = '0; ack = 0;
    t_reset_R10();
    t_edge_once_R3();
    t_priority_R1();
    t_nest_R2_R6();
    t_spec_eoi_R5();
    t_level_R4();
    t_mask_R7();
    t_force_R8();
    t_status_R11();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule